// File: doc/BRIEF.md
# Memory-Mapped Bidirectional GPIO Port

This block is an eight-pin bidirectional I/O port that software sets up through a small register bus. Two register bits set up each pin on its own: a direction bit held in the direction register and a level bit held in the level register. When the direction bit is set, the pin is a push-pull output that drives the level bit. When the direction bit is clear, the level bit switches a weak pull-up on or off, so the pin floats or is held weakly high. The block drives the pad's output enable, output value and pull-up enable for every pin.

The pad levels pass through a two-flop synchronizer. From there they feed a read-only pin view on the bus and two dedicated alternate-function outputs that follow pins 4 and 5, for example to timer capture logic. A build-time parameter marks pins 0 and 1 as not bonded out. When it is set, those two bits always read as zero through the pin view.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction and level registers read 0x00 and every pin floats: pad_oe, pad_out and pad_pu are all 0.
- R2: Each pin is set up only by its own bit in the two registers. Writing one pin's bits changes no other pin's pad controls.
- R3: A pin with direction bit 0 and level bit 0 floats: its pad_oe, pad_out and pad_pu bits are 0.
- R4: A pin with direction bit 0 and level bit 1 is an input with pull-up: pad_pu is 1, and pad_oe and pad_out are 0.
- R5: A pin with direction bit 1 is a push-pull output: pad_oe is 1, pad_out equals the level bit, and pad_pu is 0.
- R6: A write at address 0x0 (direction) or 0x1 (level) is taken on the rising edge where bus_wr is 1, and the new value shows on the register and pad outputs after that edge. Reads of these two addresses return the stored register values, not the pin levels.
- R7: Address 0x2 reads the pin levels through a two-flop synchronizer. A change on pin_in appears on bus_rdata after the second rising edge and not after the first.
- R8: alt_a follows synchronized pin 4 and alt_b follows synchronized pin 5, with the same two-edge delay and whatever the register settings.
- R9: When UNBONDED_LOW is 1, bits 1:0 read at address 0x2 are always 0. When it is 0, they follow pins 1:0.
- R10: A write to address 0x2 leaves both registers and the pad controls unchanged.
- R11: Reads of any address from 0x3 to 0xF return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| alt_a | output | 1 | Synchronized pin 4 for an alternate function |
| alt_b | output | 1 | Synchronized pin 5 for an alternate function |

## Verification
A register write is due one rising edge after the strobe. The bench drives every input at a falling edge, so it reads the register and pad results at the next falling edge. The read mux is combinational, so a read is sampled 1 ns after the address changes, with no edge in between. Pin levels and the two alternate outputs are due two edges after pin_in changes. The bench checks that the old value still shows after the first edge and that the new value shows after the second. The bench sweeps all 256 direction values against several level patterns, and it compares the pad outputs with expected values it computes bitwise.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W    = 8;
    localparam int BUS_AW    = 4;
    localparam int SYNC_LEN  = 2;

    localparam logic [BUS_AW-1:0] ADDR_DIR = 4'h0;
    localparam logic [BUS_AW-1:0] ADDR_LVL = 4'h1;
    localparam logic [BUS_AW-1:0] ADDR_PIN = 4'h2;

    // Pad mode is the {direction, level} pair of one pin
    typedef enum logic [1:0] {
        PAD_FLOAT  = 2'b00,
        PAD_PULLUP = 2'b01,
        PAD_DRIVE0 = 2'b10,
        PAD_DRIVE1 = 2'b11
    } pad_mode_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctrl_t;

    typedef enum logic [1:0] {
        SEL_DIR,
        SEL_LVL,
        SEL_PIN,
        SEL_NONE
    } reg_sel_e;

    function automatic pad_mode_e mode_of(input logic dir_bit, input logic lvl_bit);
        return pad_mode_e'({dir_bit, lvl_bit});
    endfunction

    function automatic pad_ctrl_t ctrl_of(input pad_mode_e m);
        pad_ctrl_t c;
        c = '0;
        case (m)
            PAD_FLOAT:  c = '{oe: 1'b0, out: 1'b0, pu: 1'b0};
            PAD_PULLUP: c = '{oe: 1'b0, out: 1'b0, pu: 1'b1};
            PAD_DRIVE0: c = '{oe: 1'b1, out: 1'b0, pu: 1'b0};
            PAD_DRIVE1: c = '{oe: 1'b1, out: 1'b1, pu: 1'b0};
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        reg_sel_e s;
        if (a == ADDR_DIR)      s = SEL_DIR;
        else if (a == ADDR_LVL) s = SEL_LVL;
        else if (a == ADDR_PIN) s = SEL_PIN;
        else                    s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = BUS_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  lvl_q
);
    reg_sel_e sel;

    always_comb sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else if (wr) begin
            if (sel == SEL_DIR) dir_q <= wdata;
            if (sel == SEL_LVL) lvl_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0] chain [W];

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= {chain[i][STAGES-2:0], d[i]};
        end
        assign q[i] = chain[i][STAGES-1];
    end
endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lvl_q,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pad_ctrl_t c;
        always_comb c = ctrl_of(mode_of(dir_q[i], lvl_q[i]));
        assign pad_oe[i]  = c.oe;
        assign pad_out[i] = c.out;
        assign pad_pu[i]  = c.pu;
    end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = BUS_AW
) (
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  dir_q,
    input  logic [W-1:0]  lvl_q,
    input  logic [W-1:0]  pin_view,
    output logic [W-1:0]  rdata
);
    always_comb begin
        unique case (decode_addr(addr))
            SEL_DIR:  rdata = dir_q;
            SEL_LVL:  rdata = lvl_q;
            SEL_PIN:  rdata = pin_view;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W           = PORT_W,
    parameter int AW          = BUS_AW,
    parameter int SYNC_STAGES = SYNC_LEN,
    parameter int ALT_A_BIT   = 4,
    parameter int ALT_B_BIT   = 5,
    parameter bit UNBONDED_LOW = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_pu,
    output logic          alt_a,
    output logic          alt_b
);
    localparam logic [W-1:0] READ_MASK = UNBONDED_LOW ? ~W'(3) : '1;

    logic [W-1:0] dir_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] pin_sync;
    logic [W-1:0] pin_view;

    gpio_regs #(.W(W), .AW(AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lvl_q (lvl_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_pad_decode #(.W(W)) u_pad (
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_pu  (pad_pu)
    );

    assign pin_view = pin_sync & READ_MASK;

    gpio_rd_mux #(.W(W), .AW(AW)) u_rd (
        .addr     (bus_addr),
        .dir_q    (dir_q),
        .lvl_q    (lvl_q),
        .pin_view (pin_view),
        .rdata    (bus_rdata)
    );

    assign alt_a = pin_sync[ALT_A_BIT];
    assign alt_b = pin_sync[ALT_B_BIT];
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = BUS_AW,
    parameter int ALT_A_BIT = 4,
    parameter int ALT_B_BIT = 5,
    parameter bit UNBONDED_LOW = 1'b0
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  pin_in,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  pad_out,
    input logic [W-1:0]  pad_pu,
    input logic          alt_a,
    input logic          alt_b,
    input logic [W-1:0]  dir_q,
    input logic [W-1:0]  lvl_q
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_float_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

    // R5
    no_pull_on_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_pu) == '0);

    // R3
    idle_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    // R6
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_DIR) |=> pad_oe == $past(bus_wdata));

    // R10
    pin_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_PIN) |=> ($stable(dir_q) && $stable(lvl_q)));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > ADDR_PIN) |-> bus_rdata == '0);

    // R9
    unbonded_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (UNBONDED_LOW && bus_addr == ADDR_PIN) |-> bus_rdata[1:0] == 2'b00);

    // R8
    alt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (alt_a == $past(pin_in[ALT_A_BIT], 2) &&
                                 alt_b == $past(pin_in[ALT_B_BIT], 2)));
endmodule

bind gpio_port gpio_port_chk #(
    .W(W), .AW(AW), .ALT_A_BIT(ALT_A_BIT), .ALT_B_BIT(ALT_B_BIT),
    .UNBONDED_LOW(UNBONDED_LOW)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .alt_a(alt_a), .alt_b(alt_b), .dir_q(dir_q), .lvl_q(lvl_q)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] pin_in = '0;

    logic [7:0] rdata_u, oe_u, out_u, pu_u;
    logic       alta_u, altb_u;
    logic [7:0] rdata_f, oe_f, out_f, pu_f;
    logic       alta_f, altb_f;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_port #(.UNBONDED_LOW(1'b1)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_u), .pin_in(pin_in),
        .pad_oe(oe_u), .pad_out(out_u), .pad_pu(pu_u),
        .alt_a(alta_u), .alt_b(altb_u)
    );

    gpio_port #(.UNBONDED_LOW(1'b0)) dut_full (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_f), .pin_in(pin_in),
        .pad_oe(oe_f), .pad_out(out_f), .pad_pu(pu_f),
        .alt_a(alta_f), .alt_b(altb_f)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a);
        bus_addr = a;
        #1;
    endtask

    task automatic check_pads(input string req, input logic [7:0] d, input logic [7:0] l);
        chk(req, oe_u, d);
        chk(req, out_u, d & l);
        chk(req, pu_u, ~d & l);
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(4'h0); chk("R1 dir", rdata_u, 8'h00);
        peek(4'h1); chk("R1 lvl", rdata_u, 8'h00);
        check_pads("R1", 8'h00, 8'h00);

        // R2 R3 R4 R5 R6 sweep all direction values against level patterns
        for (int d = 0; d < 256; d++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] l;
                l = pats[p] ^ 8'(d * 37);
                bus_write(4'h0, 8'(d));
                bus_write(4'h1, l);
                peek(4'h0); chk("R6 dir read", rdata_u, 8'(d));
                peek(4'h1); chk("R6 lvl read", rdata_u, l);
                check_pads("R2/R3/R4/R5", 8'(d), l);
            end
        end

        // R6 write visible after the strobe edge
        bus_write(4'h0, 8'h0F);
        bus_write(4'h1, 8'hF0);
        check_pads("R6 edge", 8'h0F, 8'hF0);

        // R10 writes to pin view ignored
        bus_write(4'h2, 8'hAA);
        check_pads("R10 pads", 8'h0F, 8'hF0);
        peek(4'h0); chk("R10 dir", rdata_u, 8'h0F);
        peek(4'h1); chk("R10 lvl", rdata_u, 8'hF0);

        // R11 unmapped addresses
        for (int a = 3; a < 16; a++) begin
            peek(4'(a)); chk("R11 unmapped", rdata_u, 8'h00);
        end

        // R7 R8 R9 pin sweep with registers in output mode
        bus_write(4'h0, 8'h30);
        bus_write(4'h1, 8'h10);
        for (int v = 0; v < 256; v++) begin
            logic [7:0] prev;
            peek(4'h2);
            prev = rdata_f;
            pin_in = 8'(v);
            @(negedge clk);
            peek(4'h2);
            chk("R7 one edge", rdata_f, prev);
            @(negedge clk);
            peek(4'h2);
            chk("R7 two edges", rdata_f, 8'(v));
            chk("R9 unbonded", rdata_u, 8'(v) & 8'hFC);
            chk("R8 alt", {6'b0, altb_u, alta_u}, {6'b0, pin_in[5], pin_in[4]});
            chk("R8 alt full", {6'b0, altb_f, alta_f}, {6'b0, pin_in[5], pin_in[4]});
        end

        // R6 read of dir is not pin level
        peek(4'h0); chk("R6 dir not pins", rdata_u, 8'h30);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule